// File: doc/BRIEF.md
# Serial Receive Queue with Interrupt Generation

This block is the receive buffering stage of a serial port that works in both asynchronous and synchronous modes. The deserializer hands it one completed frame at a time: a data word, the sampled stop bit and the received parity bit, all valid on a one-cycle strobe. The block stores frames in a small queue, and a CPU-side read port drains the queue one entry per read request. When the queue is switched off, a single buffer entry takes its place.

Two interrupt lines, one for receive and one for error, carry one-cycle pulses. Their timing depends on the queue setting, the threshold, a transparent mode and the access corner cases: a frame arriving at a full queue, a read of an empty queue, and a frame arriving at an unread single buffer. The block also checks the stop bit and the parity of each frame received in asynchronous mode. Four sticky status flags record the error events until software clears them. A flush input empties the queue at once.

All outputs are registered. A pulse, flag, fill count or read response caused by inputs sampled at a clock edge appears right after that edge.

Top module: `rxq_irq`

## Requirements
- R1: With the queue disabled (`cfg_fifo_en`=0), every accepted frame pulses `irq_rx` in the cycle after its strobe, and the single buffer holds the newest frame. A read of a non-empty buffer returns that frame on `rd_data` with `rd_valid`=1 in the cycle after the request.
- R2: With the queue enabled and transparent mode off, writes pulse `irq_rx` only when the fill count rises to the threshold. The threshold is `cfg_thresh`, and the value 0 stands for 8. Frames are read back in arrival order.
- R3: In transparent mode (queue enabled, `cfg_transp`=1), a read of a non-empty queue pulses `irq_rx` if at least one entry remains after it. A read that takes the last entry raises no `irq_rx`.
- R4: A frame that arrives at a full queue with no read in the same cycle overwrites the most recently stored entry. The fill count stays at 8, both `irq_rx` and `irq_err` pulse, and flag bit 0 (overflow) is set.
- R5: A read of an empty queue or buffer pulses `irq_err` only, sets flag bit 3 (empty read), and gives no `rd_valid`.
- R6: With the queue disabled, a frame that arrives while the buffer still holds unread data pulses both interrupts and sets flag bit 0 in synchronous mode (`cfg_sync`=1). In asynchronous mode the same case pulses `irq_rx` only.
- R7: In asynchronous mode, a frame whose stop bit was sampled low pulses both interrupts and sets flag bit 1 (frame error). The frame is still stored. In synchronous mode the stop bit is ignored.
- R8: In asynchronous mode with `cfg_par_en`=1, a parity bit that differs from the XOR of the data bits pulses both interrupts and sets flag bit 2 (parity error). For odd parity (`cfg_par_odd`=1), the parity bit is compared with the inverted XOR.
- R9: `flush` sets the fill count to 0 in the next cycle and raises no interrupt. A frame or read request in the same cycle is ignored.
- R10: A frame and a read request in the same cycle on a full queue perform the read first. No overflow is reported, the fill count stays at 8 and the oldest entry is returned.
- R11: The flags are sticky. Each bit of `clr_flags` clears the flag bit at the same position. A set event in the same cycle takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_fifo_en | input | 1 | 1: queue of DEPTH entries, 0: single buffer |
| cfg_transp | input | 1 | Transparent receive interrupt mode |
| cfg_sync | input | 1 | 1: synchronous mode, 0: asynchronous mode |
| cfg_thresh | input | THR_W | Fill threshold, 0 means DEPTH |
| cfg_par_en | input | 1 | Parity check enable |
| cfg_par_odd | input | 1 | Odd parity select |
| frm_vld | input | 1 | Frame strobe from the deserializer |
| frm_data | input | DATA_W | Frame data |
| frm_stop | input | 1 | Sampled stop bit |
| frm_par | input | 1 | Received parity bit |
| rd_req | input | 1 | CPU read request |
| flush | input | 1 | Empty the queue |
| clr_flags | input | 4 | Per-bit clear for the sticky flags |
| rd_data | output | DATA_W | Read response data |
| rd_valid | output | 1 | Read response valid |
| irq_rx | output | 1 | Receive interrupt pulse |
| irq_err | output | 1 | Error interrupt pulse |
| fill | output | CNT_W | Number of stored entries |
| flags | output | 4 | Sticky flags: 0 overflow, 1 frame, 2 parity, 3 empty read |

## Verification
The assertions check the following rules on every cycle:
- overwrite on a full queue (R4);
- the empty-read error (R5);
- the quiet flush (R9);
- read-before-write on a full queue (R10);
- the frame-error pulse (R7);
- the pulse per frame with the queue off (R1);
- the last-entry read in transparent mode (R3);
- the bound on the fill count.

The bench scenarios are needed for the rest:
- which entry an overflow replaced, and the order of the data read back;
- the exact threshold crossing, including the 0-means-8 case;
- both parity polarities;
- the sticky flags and their clear priority.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int FLAG_W   = 4;
    localparam int FLG_OVF  = 0;
    localparam int FLG_FRM  = 1;
    localparam int FLG_PAR  = 2;
    localparam int FLG_EMPT = 3;
endpackage

// File: rtl/rxq_frame_chk.sv
module rxq_frame_chk #(
    parameter int DATA_W = 9
) (
    input  logic              vld,
    input  logic              sync_mode,
    input  logic [DATA_W-1:0] data,
    input  logic              stop_bit,
    input  logic              par_bit,
    input  logic              par_en,
    input  logic              par_odd,
    output logic              frame_err,
    output logic              parity_err
);
    logic par_expect;

    always_comb begin
        par_expect = (^data) ^ par_odd;
        frame_err  = vld && !sync_mode && !stop_bit;
        parity_err = vld && !sync_mode && par_en && (par_bit != par_expect);
    end
endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DATA_W = 9,
    parameter int DEPTH  = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [PTR_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [PTR_W-1:0]  ridx,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] ent [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (we && (widx == PTR_W'(i))) begin
                ent[i] <= wdata;
            end
        end
    end

    assign rdata = ent[ridx];
endmodule

// File: rtl/rxq_irq.sv
module rxq_irq #(
    parameter int DATA_W = 9,
    parameter int DEPTH  = 8,
    localparam int THR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_fifo_en,
    input  logic              cfg_transp,
    input  logic              cfg_sync,
    input  logic [THR_W-1:0]  cfg_thresh,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              frm_vld,
    input  logic [DATA_W-1:0] frm_data,
    input  logic              frm_stop,
    input  logic              frm_par,
    input  logic              rd_req,
    input  logic              flush,
    input  logic [3:0]        clr_flags,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              irq_rx,
    output logic              irq_err,
    output logic [CNT_W-1:0]  fill,
    output logic [3:0]        flags
);
    import rxq_pkg::*;

    localparam int PTR_W = $clog2(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0]  wr_ptr;
        logic [PTR_W-1:0]  rd_ptr;
        logic [CNT_W-1:0]  count;
        logic [DATA_W-1:0] rd_data;
        logic              rd_vld;
        logic              irq_rx;
        logic              irq_err;
        logic [FLAG_W-1:0] flags;
    } st_t;

    st_t s_d, s_q;

    logic              wr_ok;
    logic              rd_hit;
    logic              rd_empty;
    logic              push;
    logic              ovw;
    logic              full_after;
    logic [CNT_W-1:0]  cap;
    logic [CNT_W-1:0]  thr_eff;
    logic [CNT_W-1:0]  cnt_after_rd;
    logic              mem_we;
    logic [PTR_W-1:0]  mem_widx;
    logic [DATA_W-1:0] mem_rdata;
    logic              frame_err;
    logic              parity_err;
    logic [FLAG_W-1:0] set_flags;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    function automatic logic [PTR_W-1:0] ptr_dec(input logic [PTR_W-1:0] p);
        return (p == '0) ? PTR_W'(DEPTH - 1) : p - 1'b1;
    endfunction

    rxq_frame_chk #(.DATA_W(DATA_W)) u_fchk (
        .vld        (wr_ok),
        .sync_mode  (cfg_sync),
        .data       (frm_data),
        .stop_bit   (frm_stop),
        .par_bit    (frm_par),
        .par_en     (cfg_par_en),
        .par_odd    (cfg_par_odd),
        .frame_err  (frame_err),
        .parity_err (parity_err)
    );

    rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .we    (mem_we),
        .widx  (mem_widx),
        .wdata (frm_data),
        .ridx  (s_q.rd_ptr),
        .rdata (mem_rdata)
    );

    always_comb begin
        cap          = cfg_fifo_en ? CNT_W'(DEPTH) : CNT_W'(1);
        thr_eff      = (cfg_thresh == '0) ? CNT_W'(DEPTH) : CNT_W'(cfg_thresh);
        wr_ok        = frm_vld && !flush;
        rd_hit       = rd_req && (s_q.count != '0) && !flush;
        rd_empty     = rd_req && (s_q.count == '0) && !flush;
        cnt_after_rd = s_q.count - CNT_W'(rd_hit);
        full_after   = (cnt_after_rd == cap);
        push         = wr_ok && !full_after;
        ovw          = wr_ok && full_after;
        mem_we       = push || ovw;
        if (push || !cfg_fifo_en) begin
            mem_widx = cfg_fifo_en ? s_q.wr_ptr : '0;
        end else begin
            mem_widx = ptr_dec(s_q.wr_ptr);
        end
    end

    always_comb begin
        s_d         = s_q;
        s_d.rd_vld  = 1'b0;
        s_d.irq_rx  = 1'b0;
        s_d.irq_err = 1'b0;
        set_flags   = '0;

        if (flush) begin
            s_d.wr_ptr = '0;
            s_d.rd_ptr = '0;
            s_d.count  = '0;
        end else begin
            if (rd_hit) begin
                s_d.rd_data = mem_rdata;
                s_d.rd_vld  = 1'b1;
                s_d.rd_ptr  = cfg_fifo_en ? ptr_inc(s_q.rd_ptr) : '0;
            end
            if (push) begin
                s_d.wr_ptr = cfg_fifo_en ? ptr_inc(s_q.wr_ptr) : '0;
            end
            s_d.count = cnt_after_rd + CNT_W'(push);

            if (rd_empty) begin
                s_d.irq_err         = 1'b1;
                set_flags[FLG_EMPT] = 1'b1;
            end
            if (ovw) begin
                s_d.irq_rx = 1'b1;
                if (cfg_fifo_en || cfg_sync) begin
                    s_d.irq_err        = 1'b1;
                    set_flags[FLG_OVF] = 1'b1;
                end
            end
            if (push) begin
                if (!cfg_fifo_en) begin
                    s_d.irq_rx = 1'b1;
                end else if (!cfg_transp && (s_d.count == thr_eff) &&
                             (s_q.count != thr_eff)) begin
                    s_d.irq_rx = 1'b1;
                end
            end
            if (cfg_fifo_en && cfg_transp && rd_hit && (s_d.count != '0)) begin
                s_d.irq_rx = 1'b1;
            end
            if (frame_err) begin
                s_d.irq_rx         = 1'b1;
                s_d.irq_err        = 1'b1;
                set_flags[FLG_FRM] = 1'b1;
            end
            if (parity_err) begin
                s_d.irq_rx         = 1'b1;
                s_d.irq_err        = 1'b1;
                set_flags[FLG_PAR] = 1'b1;
            end
        end

        s_d.flags = (s_q.flags & ~clr_flags) | set_flags;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_data  = s_q.rd_data;
    assign rd_valid = s_q.rd_vld;
    assign irq_rx   = s_q.irq_rx;
    assign irq_err  = s_q.irq_err;
    assign fill     = s_q.count;
    assign flags    = s_q.flags;
endmodule

// File: rtl/rxq_irq_chk.sv
module rxq_irq_chk #(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_fifo_en,
    input logic             cfg_transp,
    input logic             cfg_sync,
    input logic             frm_vld,
    input logic             frm_stop,
    input logic             rd_req,
    input logic             flush,
    input logic [CNT_W-1:0] fill,
    input logic             irq_rx,
    input logic             irq_err,
    input logic [3:0]       flags,
    input logic             rd_valid
);
    a_r4_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CNT_W'(DEPTH));

    a_r4_full_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_fifo_en && fill == CNT_W'(DEPTH) && frm_vld && !rd_req && !flush)
        |=> (irq_rx && irq_err && fill == CNT_W'(DEPTH) && flags[0]));

    a_r10_read_first: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_fifo_en && fill == CNT_W'(DEPTH) && frm_vld && rd_req && !flush)
        |=> (fill == CNT_W'(DEPTH) && rd_valid));

    a_r5_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && fill == '0 && !flush) |=> (irq_err && !rd_valid && flags[3]));

    a_r9_flush_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (fill == '0 && !irq_rx && !irq_err && !rd_valid));

    a_r1_direct_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_fifo_en && frm_vld && !flush) |=> irq_rx);

    a_r7_stop_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_sync && frm_vld && !frm_stop && !flush) |=> (irq_rx && irq_err && flags[1]));

    a_r3_last_read: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_fifo_en && cfg_transp && rd_req && fill == CNT_W'(1) && !frm_vld && !flush)
        |=> !irq_rx);
endmodule

bind rxq_irq rxq_irq_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_fifo_en (cfg_fifo_en),
    .cfg_transp  (cfg_transp),
    .cfg_sync    (cfg_sync),
    .frm_vld     (frm_vld),
    .frm_stop    (frm_stop),
    .rd_req      (rd_req),
    .flush       (flush),
    .fill        (fill),
    .irq_rx      (irq_rx),
    .irq_err     (irq_err),
    .flags       (flags),
    .rd_valid    (rd_valid)
);

// File: tb/rxq_irq_tb.sv
module rxq_irq_tb;
    localparam int DATA_W = 9;
    localparam int DEPTH  = 8;
    localparam int THR_W  = 3;
    localparam int CNT_W  = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_fifo_en = 1'b0, cfg_transp = 1'b0, cfg_sync = 1'b0;
    logic [THR_W-1:0]  cfg_thresh = '0;
    logic              cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
    logic              frm_vld = 1'b0, frm_stop = 1'b1, frm_par = 1'b0;
    logic [DATA_W-1:0] frm_data = '0;
    logic              rd_req = 1'b0, flush = 1'b0;
    logic [3:0]        clr_flags = '0;
    logic [DATA_W-1:0] rd_data;
    logic              rd_valid, irq_rx, irq_err;
    logic [CNT_W-1:0]  fill;
    logic [3:0]        flags;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [DATA_W-1:0] exp_q [$];

    always #2 clk = ~clk;

    rxq_irq #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_fifo_en(cfg_fifo_en), .cfg_transp(cfg_transp),
        .cfg_sync(cfg_sync), .cfg_thresh(cfg_thresh), .cfg_par_en(cfg_par_en),
        .cfg_par_odd(cfg_par_odd), .frm_vld(frm_vld), .frm_data(frm_data),
        .frm_stop(frm_stop), .frm_par(frm_par), .rd_req(rd_req), .flush(flush),
        .clr_flags(clr_flags), .rd_data(rd_data), .rd_valid(rd_valid),
        .irq_rx(irq_rx), .irq_err(irq_err), .fill(fill), .flags(flags)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic good_par(input logic [DATA_W-1:0] d);
        return (^d) ^ cfg_par_odd;
    endfunction

    task automatic step(input logic fv, input logic [DATA_W-1:0] d, input logic st,
                        input logic pb, input logic rd, input logic fl,
                        input logic [3:0] clr);
        frm_vld = fv; frm_data = d; frm_stop = st; frm_par = pb;
        rd_req = rd; flush = fl; clr_flags = clr;
        @(negedge clk);
        frm_vld = 1'b0; frm_stop = 1'b1; rd_req = 1'b0; flush = 1'b0; clr_flags = '0;
    endtask

    task automatic put(input logic [DATA_W-1:0] d);
        step(1'b1, d, 1'b1, good_par(d), 1'b0, 1'b0, 4'b0);
    endtask

    task automatic get(input logic [DATA_W-1:0] expd);
        exp_q.push_back(expd);
        step(1'b0, '0, 1'b1, 1'b0, 1'b1, 1'b0, 4'b0);
    endtask

    task automatic irqs(input string tag, input logic erx, input logic eerr);
        chk({tag, " irq_rx"}, int'(irq_rx), int'(erx));
        chk({tag, " irq_err"}, int'(irq_err), int'(eerr));
    endtask

    // monitor: pops the scoreboard on each read response
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                chk("R5 unexpected rd_valid", 1, 0);
            end else begin
                chk("R2 read data order", int'(rd_data), int'(exp_q.pop_front()));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("reset fill", int'(fill), 0);
        chk("reset flags", int'(flags), 0);
        irqs("reset", 1'b0, 1'b0);

        // R1: single buffer, asynchronous
        put(9'h0A5);
        irqs("R1 frame", 1'b1, 1'b0);
        chk("R1 fill", int'(fill), 1);
        get(9'h0A5);
        chk("R1 fill after read", int'(fill), 0);

        // R6: asynchronous overwrite of unread buffer
        put(9'h011);
        put(9'h022);
        irqs("R6 async unread", 1'b1, 1'b0);
        get(9'h022);
        cfg_sync = 1'b1;
        put(9'h033);
        put(9'h044);
        irqs("R6 sync unread", 1'b1, 1'b1);
        chk("R6 overflow flag", int'(flags), 1);
        get(9'h044);
        step(1'b0, '0, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0001);
        chk("R11 clear overflow", int'(flags), 0);
        cfg_sync = 1'b0;

        // R2: queue with threshold 3
        cfg_fifo_en = 1'b1;
        cfg_thresh = 3'd3;
        step(1'b0, '0, 1'b1, 1'b0, 1'b0, 1'b1, 4'b0);
        put(9'd1); irqs("R2 fill1", 1'b0, 1'b0);
        put(9'd2); irqs("R2 fill2", 1'b0, 1'b0);
        put(9'd3); irqs("R2 fill3", 1'b1, 1'b0);
        put(9'd4); irqs("R2 fill4", 1'b0, 1'b0);
        for (int i = 1; i <= 4; i++) get(9'(i));
        chk("R2 drained", int'(fill), 0);

        // R2: threshold 0 means 8, then R4 overflow
        cfg_thresh = 3'd0;
        for (int i = 0; i < 7; i++) put(9'(10 + i));
        irqs("R2 fill7 thr0", 1'b0, 1'b0);
        put(9'd17);
        irqs("R2 fill8 thr0", 1'b1, 1'b0);
        chk("R2 full", int'(fill), 8);
        put(9'd99);
        irqs("R4 overflow", 1'b1, 1'b1);
        chk("R4 fill stays", int'(fill), 8);
        chk("R4 flag", int'(flags), 1);
        step(1'b0, '0, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0001);
        for (int i = 0; i < 7; i++) get(9'(10 + i));
        get(9'd99);
        chk("R4 drained", int'(fill), 0);

        // R10: simultaneous read and write on a full queue
        for (int i = 0; i < 8; i++) put(9'(20 + i));
        exp_q.push_back(9'd20);
        step(1'b1, 9'd28, 1'b1, 1'b0, 1'b1, 1'b0, 4'b0);
        chk("R10 no error", int'(irq_err), 0);
        chk("R10 fill", int'(fill), 8);
        chk("R10 no flag", int'(flags), 0);
        for (int i = 1; i <= 8; i++) get(9'(20 + i));

        // R5: empty read
        step(1'b0, '0, 1'b1, 1'b0, 1'b1, 1'b0, 4'b0);
        irqs("R5 empty read", 1'b0, 1'b1);
        chk("R5 flag", int'(flags), 8);
        chk("R5 fill", int'(fill), 0);
        step(1'b0, '0, 1'b1, 1'b0, 1'b0, 1'b0, 4'b1000);

        // R9: flush with same-cycle frame and read
        put(9'd30); put(9'd31); put(9'd32);
        step(1'b1, 9'd33, 1'b0, 1'b0, 1'b1, 1'b1, 4'b0);
        chk("R9 fill", int'(fill), 0);
        irqs("R9 flush", 1'b0, 1'b0);
        chk("R9 no flags", int'(flags), 0);
        put(9'd34);
        get(9'd34);
        chk("R9 only new frame", int'(fill), 0);

        // R3: transparent mode
        cfg_transp = 1'b1;
        put(9'd40); put(9'd41); put(9'd42);
        get(9'd40); irqs("R3 two left", 1'b1, 1'b0);
        get(9'd41); irqs("R3 one left", 1'b1, 1'b0);
        get(9'd42); irqs("R3 none left", 1'b0, 1'b0);
        cfg_transp = 1'b0;

        // R7: frame error, asynchronous and synchronous
        step(1'b1, 9'd50, 1'b0, good_par(9'd50), 1'b0, 1'b0, 4'b0);
        irqs("R7 stop low", 1'b1, 1'b1);
        chk("R7 flag", int'(flags), 2);
        chk("R7 stored", int'(fill), 1);
        get(9'd50);
        cfg_sync = 1'b1;
        step(1'b1, 9'd51, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0);
        irqs("R7 sync ignores stop", 1'b0, 1'b0);
        get(9'd51);
        cfg_sync = 1'b0;

        // R8: parity, even then odd (flags: bit1 frame still set)
        cfg_par_en = 1'b1;
        step(1'b1, 9'h003, 1'b1, 1'b1, 1'b0, 1'b0, 4'b0);
        irqs("R8 even mismatch", 1'b1, 1'b1);
        chk("R8 flag", int'(flags), 6);
        put(9'h007);
        chk("R8 even match", int'(irq_err), 0);
        cfg_par_odd = 1'b1;
        step(1'b1, 9'h003, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0);
        irqs("R8 odd mismatch", 1'b1, 1'b1);
        put(9'h005);
        chk("R8 odd match", int'(irq_err), 0);
        get(9'h003); get(9'h007); get(9'h003); get(9'h005);
        cfg_par_en = 1'b0;
        cfg_par_odd = 1'b0;

        // R11: per-bit clear and set priority
        step(1'b0, '0, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0010);
        chk("R11 clear frame only", int'(flags), 4);
        step(1'b1, 9'd60, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0010);
        chk("R11 set wins", int'(flags), 6);
        get(9'd60);
        step(1'b0, '0, 1'b1, 1'b0, 1'b0, 1'b0, 4'b1111);
        chk("R11 clear all", int'(flags), 0);

        @(negedge clk);
        chk("R2 scoreboard empty", exp_q.size(), 0);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule